// File: doc/BRIEF.md
# Float32 Normalise, Round and Pack Stage

This block is the final stage of a single-precision floating-point datapath. An arithmetic operator upstream hands it an unpacked intermediate result: a sign, a signed biased exponent and a 32-bit significand that carries guard and sticky information below the fraction. The stage turns this value into a packed IEEE-754 binary32 word and reports the exceptions that rounding produced, merged with any exceptions the operator already raised.

Inside, the value is shifted left until its leading one is at the top, pushed right with sticky jamming when it is too small for a normal exponent, and rounded in one of four modes. Rounding is done by adding one increment that depends on the mode, the sign and the kept LSB. A carry out of that addition renormalises the value before the fraction is kept. Results whose exponent is too large saturate to the largest finite magnitude or to infinity, depending on the mode. Results that stay subnormal and lose bits raise underflow. The stage has one register: a result appears one clock after its input is marked valid.

Top module: `nrp_round_pack`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_word` and `out_flags` are all zero. A result is presented with `out_valid` high exactly one clock after `in_valid` is high, and `out_valid` is low one clock after `in_valid` is low.
- R2: An input whose exponent equals 255 and whose significand is zero, or that arrives with any nonzero `in_flags`, is packed as {sign, 8'hFF, in_sig[29:7]}, and `out_flags` equals `in_flags`.
- R3: An input with a zero significand (and an exponent other than 255) gives a signed zero {sign, 31'b0}, and `out_flags` equals `in_flags`.
- R4: Any other input is read as the value (-1)^sign × in_sig × 2^(in_exp − 157). Its significand is shifted left until bit 31 is set, and the exponent is lowered by the shift count. The packed magnitude is (exponent << 23) plus bits [31:8] of the rounded significand, so a bit that reaches bit 31 adds one to the exponent field.
- R5: If the exponent after normalisation is negative, the significand is shifted right by its magnitude, with every bit shifted out OR-ed into bit 0, and the exponent becomes 0. A shift of 32 or more leaves only the sticky bit.
- R6: The rounding mode is encoded in `rmode` as 00 nearest-even, 01 toward +infinity, 10 toward -infinity and 11 toward zero. The increment added at bit 0 is as follows. For nearest it is 0x80, or 0x7F when bit 8 is 0. For toward zero it is 0. For a directed mode it is 0xFF when the mode rounds away from zero for this sign, and 0 otherwise.
- R7: If adding the increment would carry out of bit 31, the exponent is raised by one and the significand is shifted right by one, with its old bit 0 OR-ed back into bit 0. The increment is then halved before it is added.
- R8: The inexact flag (`out_flags[1]`) is set when bits [7:0] are nonzero just before the increment is added.
- R9: When the exponent is 254 or more after step R7, the overflow flag (`out_flags[3]`) and the inexact flag are set. The magnitude is 0x7F7FFFFF if the increment was zero and 0x7F800000 otherwise.
- R10: The underflow flag (`out_flags[2]`) is set only for a value that went through R5, lost nonzero bits there, and after rounding still has a zero exponent and a significand no greater than 0x80000000. A rounded significand with bits [31:8] all zero forces the exponent to 0.
- R11: `out_flags` is {overflow, underflow, inexact, invalid} OR-ed with `in_flags`. The stage never raises the invalid bit itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input holds a value to convert this cycle |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | EXP_W | Signed biased exponent |
| in_sig | input | 32 | Significand, hidden bit at 30, guard bits [6:0] |
| rmode | input | 2 | Rounding mode (R6 encoding) |
| in_flags | input | 4 | Exceptions already raised upstream |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Packed binary32 result |
| out_flags | output | 4 | {overflow, underflow, inexact, invalid} |

## Verification
The bench targets the exact tie in nearest mode. A design that ignores the kept LSB rounds ties up and gets odd fractions. It drives all-ones significands, which carry out during rounding; a stage that drops the old bit 0 or keeps the full increment misrounds or gets the exponent wrong by one. It probes the overflow threshold under each mode, where swapping the saturate and infinity choices is caught, and tiny values at exponent -1 that round up into the normal range, where a stage that raises underflow too eagerly is exposed. The pass-through of infinities and of NaNs with pending exceptions is set against NaNs without exceptions, which must take the arithmetic path and overflow.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

  localparam int SIG_W   = 32;
  localparam int GRD_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int EXPF_W  = 8;
  localparam int FLAG_W  = 4;

  localparam int FLG_OVF = 3;
  localparam int FLG_UNF = 2;
  localparam int FLG_INX = 1;
  localparam int FLG_INV = 0;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  // count of zero bits above the leading one (SIG_W when the word is zero)
  function automatic logic [5:0] lead_zeros(input logic [SIG_W-1:0] v);
    logic [5:0] n;
    n = 6'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (v[i]) n = 6'(SIG_W - 1 - i);
    end
    return n;
  endfunction

  // right shift that folds every discarded bit into bit 0
  function automatic logic [SIG_W-1:0] shr_jam(input logic [SIG_W-1:0] v,
                                               input logic [15:0] amt);
    logic [SIG_W-1:0] mask;
    logic [SIG_W-1:0] res;
    if (amt >= 16'(SIG_W)) begin
      res = {{(SIG_W-1){1'b0}}, |v};
    end else begin
      mask = (SIG_W'(1) << amt[4:0]) - SIG_W'(1);
      res  = (v >> amt[4:0]) | {{(SIG_W-1){1'b0}}, |(v & mask)};
    end
    return res;
  endfunction

endpackage

// File: rtl/nrp_normalize.sv
module nrp_normalize
  import nrp_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int IEXP_W = EXP_W + 2
) (
  input  logic        [SIG_W-1:0]  sig_i,
  input  logic signed [EXP_W-1:0]  exp_i,
  output logic        [SIG_W-1:0]  sig_o,
  output logic signed [IEXP_W-1:0] exp_o
);

  logic        [5:0]        lz;
  logic signed [IEXP_W-1:0] exp_ext;

  always_comb begin
    lz      = lead_zeros(sig_i);
    exp_ext = IEXP_W'(exp_i);
    if (lz < 6'(SIG_W)) begin
      sig_o = sig_i << lz;
      exp_o = exp_ext - IEXP_W'(lz);
    end else begin
      sig_o = sig_i;
      exp_o = exp_ext;
    end
  end

endmodule

// File: rtl/nrp_tiny.sv
module nrp_tiny
  import nrp_pkg::*;
#(
  parameter int IEXP_W = 12
) (
  input  logic        [SIG_W-1:0]  sig_i,
  input  logic signed [IEXP_W-1:0] exp_i,
  output logic        [SIG_W-1:0]  sig_o,
  output logic signed [IEXP_W-1:0] exp_o,
  output logic                     tiny_o
);

  logic        neg;
  logic [15:0] amt;

  always_comb begin
    neg = exp_i < 0;
    amt = 16'(-exp_i);
    if (neg) begin
      sig_o = shr_jam(sig_i, amt);
      exp_o = '0;
    end else begin
      sig_o = sig_i;
      exp_o = exp_i;
    end
    tiny_o = neg && (|sig_o[GRD_W-1:0]);
  end

endmodule

// File: rtl/nrp_rounder.sv
module nrp_rounder
  import nrp_pkg::*;
#(
  parameter int IEXP_W = 12
) (
  input  logic                     sign_i,
  input  logic [1:0]               rmode_i,
  input  logic        [SIG_W-1:0]  sig_i,
  input  logic signed [IEXP_W-1:0] exp_i,
  input  logic                     tiny_i,
  output logic [SIG_W-2:0]         mag_o,
  output logic                     ovf_o,
  output logic                     unf_o,
  output logic                     inx_o
);

  localparam logic [SIG_W-1:0] INC_HALF = SIG_W'(1) << (GRD_W - 1);
  localparam logic [SIG_W-1:0] INC_ALL  = (SIG_W'(1) << GRD_W) - SIG_W'(1);
  localparam logic signed [IEXP_W-1:0] EXP_SAT = IEXP_W'(254);
  localparam logic [SIG_W-1:0] SUB_LIMIT = SIG_W'(1) << (SIG_W - 1);
  localparam logic [SIG_W-2:0] MAG_INF  = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [SIG_W-2:0] MAG_MAXF = {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  logic [SIG_W-1:0]         incr;
  logic [SIG_W-1:0]         inc;
  logic [SIG_W-1:0]         m;
  logic [SIG_W:0]           trial;
  logic signed [IEXP_W-1:0] e;

  always_comb begin
    unique case (rmode_i)
      RM_NEAREST: incr = sig_i[GRD_W] ? INC_HALF : INC_HALF - SIG_W'(1);
      RM_UP:      incr = sign_i ? '0 : INC_ALL;
      RM_DOWN:    incr = sign_i ? INC_ALL : '0;
      default:    incr = '0;
    endcase

    m     = sig_i;
    e     = exp_i;
    inc   = incr;
    trial = {1'b0, sig_i} + {1'b0, incr};
    if (trial[SIG_W]) begin
      e   = e + IEXP_W'(1);
      m   = {1'b0, m[SIG_W-1:1]} | {{(SIG_W-1){1'b0}}, m[0]};
      inc = inc >> 1;
    end

    inx_o = |m[GRD_W-1:0];
    m     = m + inc;
    ovf_o = 1'b0;
    unf_o = tiny_i;

    if (e >= EXP_SAT) begin
      ovf_o = 1'b1;
      inx_o = 1'b1;
      unf_o = 1'b0;
      mag_o = (inc == '0) ? MAG_MAXF : MAG_INF;
    end else begin
      if (m[SIG_W-1:GRD_W] == '0) e = '0;
      if ((e != '0) || (m > SUB_LIMIT)) unf_o = 1'b0;
      mag_o = {e[EXPF_W-1:0], {FRAC_W{1'b0}}} + (SIG_W-1)'(m[SIG_W-1:GRD_W]);
    end
  end

endmodule

// File: rtl/nrp_round_pack.sv
module nrp_round_pack
  import nrp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [31:0]             in_sig,
  input  logic [1:0]              rmode,
  input  logic [3:0]              in_flags,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic [3:0]              out_flags
);

  localparam int IEXP_W = EXP_W + 2;
  localparam logic signed [EXP_W-1:0] EXP_SPECIAL = EXP_W'(255);

  logic [SIG_W-1:0]         n_sig;
  logic signed [IEXP_W-1:0] n_exp;
  logic [SIG_W-1:0]         t_sig;
  logic signed [IEXP_W-1:0] t_exp;
  logic                     t_tiny;
  logic [SIG_W-2:0]         r_mag;
  logic                     r_ovf;
  logic                     r_unf;
  logic                     r_inx;

  logic                     is_pass;
  logic                     is_zero;
  logic [SIG_W-1:0]         word_d;
  logic [FLAG_W-1:0]        flags_d;

  nrp_normalize #(.EXP_W(EXP_W), .IEXP_W(IEXP_W)) u_norm (
    .sig_i (in_sig),
    .exp_i (in_exp),
    .sig_o (n_sig),
    .exp_o (n_exp)
  );

  nrp_tiny #(.IEXP_W(IEXP_W)) u_tiny (
    .sig_i  (n_sig),
    .exp_i  (n_exp),
    .sig_o  (t_sig),
    .exp_o  (t_exp),
    .tiny_o (t_tiny)
  );

  nrp_rounder #(.IEXP_W(IEXP_W)) u_rnd (
    .sign_i  (in_sign),
    .rmode_i (rmode),
    .sig_i   (t_sig),
    .exp_i   (t_exp),
    .tiny_i  (t_tiny),
    .mag_o   (r_mag),
    .ovf_o   (r_ovf),
    .unf_o   (r_unf),
    .inx_o   (r_inx)
  );

  always_comb begin
    is_pass = (in_exp == EXP_SPECIAL) && ((in_sig == '0) || (in_flags != '0));
    is_zero = (in_sig == '0);
    if (is_pass) begin
      word_d  = {in_sign, {EXPF_W{1'b1}}, in_sig[29:7]};
      flags_d = in_flags;
    end else if (is_zero) begin
      word_d  = {in_sign, {(SIG_W-1){1'b0}}};
      flags_d = in_flags;
    end else begin
      word_d  = {in_sign, r_mag};
      flags_d = in_flags;
      flags_d[FLG_OVF] = in_flags[FLG_OVF] | r_ovf;
      flags_d[FLG_UNF] = in_flags[FLG_UNF] | r_unf;
      flags_d[FLG_INX] = in_flags[FLG_INX] | r_inx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= word_d;
        out_flags <= flags_d;
      end
    end
  end

endmodule

// File: rtl/nrp_round_pack_chk.sv
module nrp_round_pack_chk #(
  parameter int EXP_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [31:0]             in_sig,
  input logic [1:0]              rmode,
  input logic [3:0]              in_flags,
  input logic                    out_valid,
  input logic [31:0]             out_word,
  input logic [3:0]              out_flags
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == 32'h0 && out_flags == 4'h0));

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_inf_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_exp == EXP_W'(255) && in_sig == 32'h0) |=>
      (out_word == {$past(in_sign), 31'h7F800000} && out_flags == $past(in_flags)));

  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sig == 32'h0 && in_exp != EXP_W'(255)) |=>
      (out_word[30:0] == 31'h0 && out_flags == $past(in_flags)));

  p_rz_no_inf_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rmode == 2'b11 && in_flags == 4'h0 && in_exp != EXP_W'(255)) |=>
      (out_word[30:0] != 31'h7F800000));

  p_ovf_shape_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_flags == 4'h0) |=>
      (!out_flags[3] || (out_flags[1] &&
        (out_word[30:0] == 31'h7F800000 || out_word[30:0] == 31'h7F7FFFFF))));

  p_unf_tiny_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_flags == 4'h0) |=>
      (!out_flags[2] || (out_flags[1] && out_word[30:23] <= 8'd1 && !out_flags[3])));

  p_flag_or_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_flags & $past(in_flags)) == $past(in_flags)));

  p_inv_kept_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_flags[0] == $past(in_flags[0])));

endmodule

bind nrp_round_pack nrp_round_pack_chk #(.EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sign   (in_sign),
  .in_exp    (in_exp),
  .in_sig    (in_sig),
  .rmode     (rmode),
  .in_flags  (in_flags),
  .out_valid (out_valid),
  .out_word  (out_word),
  .out_flags (out_flags)
);

// File: tb/sim_nrp_round_pack.sv
module sim_nrp_round_pack;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W      = 10;
  localparam int N_RANDOM   = 3000;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic                    in_sign = 1'b0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [31:0]             in_sig = '0;
  logic [1:0]              rmode = '0;
  logic [3:0]              in_flags = '0;
  logic                    out_valid;
  logic [31:0]             out_word;
  logic [3:0]              out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrp_round_pack #(.EXP_W(EXP_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sign   (in_sign),
    .in_exp    (in_exp),
    .in_sig    (in_sig),
    .rmode     (rmode),
    .in_flags  (in_flags),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_flags (out_flags)
  );

  // expected {flags, word} built from the requirement text
  function automatic logic [35:0] ref_model(input logic s, input int e,
                                            input logic [31:0] g,
                                            input logic [1:0] rm,
                                            input logic [3:0] fi);
    longint      ex;
    logic [31:0] m;
    logic [31:0] inc;
    logic [31:0] lost;
    logic [32:0] sum;
    logic        unf;
    logic        inx;
    int          sh;
    logic [30:0] mag;
    if (e == 255 && (g == 0 || fi != 0)) return {fi, s, 8'hFF, g[29:7]};
    if (g == 0) return {fi, s, 31'b0};
    ex = e;
    m  = g;
    while (!m[31]) begin
      m  = m << 1;
      ex = ex - 1;
    end
    unf = 1'b0;
    if (ex < 0) begin
      sh = int'(-ex);
      if (sh >= 32) begin
        m = 32'h1;
      end else begin
        lost = m & ~(32'hFFFF_FFFF << sh);
        m    = (m >> sh) | {31'b0, lost != 0};
      end
      ex  = 0;
      unf = (m[7:0] != 0);
    end
    case (rm)
      2'b00:   inc = m[8] ? 32'h80 : 32'h7F;
      2'b01:   inc = s ? 32'h0 : 32'hFF;
      2'b10:   inc = s ? 32'hFF : 32'h0;
      default: inc = 32'h0;
    endcase
    sum = {1'b0, m} + {1'b0, inc};
    if (sum[32]) begin
      ex  = ex + 1;
      m   = (m >> 1) | (m & 32'h1);
      inc = inc >> 1;
    end
    inx = (m[7:0] != 0);
    m   = m + inc;
    if (ex >= 254)
      return {fi | 4'b1010, s, (inc == 0) ? 31'h7F7FFFFF : 31'h7F800000};
    if (m[31:8] == 0) ex = 0;
    if (ex != 0 || m > 32'h8000_0000) unf = 1'b0;
    mag = 31'(ex << 23) + 31'(m >> 8);
    return {fi | {1'b0, unf, inx, 1'b0}, s, mag};
  endfunction

  task automatic check_word(input string tag, input logic [31:0] exp_w,
                            input logic [3:0] exp_f);
    checks++;
    if (out_word !== exp_w || out_flags !== exp_f) begin
      errors++;
      $display("FAIL %s: word=%h flags=%b expected word=%h flags=%b",
               tag, out_word, out_flags, exp_w, exp_f);
    end
  endtask

  task automatic apply(input string tag, input logic s, input int e,
                       input logic [31:0] g, input logic [1:0] rm,
                       input logic [3:0] fi);
    logic [35:0] exp_v;
    exp_v = ref_model(s, e, g, rm, fi);
    @(negedge clk);
    in_valid = 1'b1;
    in_sign  = s;
    in_exp   = EXP_W'(e);
    in_sig   = g;
    rmode    = rm;
    in_flags = fi;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R1: out_valid=%b expected 1", out_valid);
    end
    check_word(tag, exp_v[31:0], exp_v[35:32]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired, done=%b expected 1", done);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check_word("R1 reset", 32'h0, 4'h0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%b expected 0", out_valid);
    end
    rst = 1'b0;

    // R4 exact value 1.0
    apply("R4 one", 1'b0, 127, 32'h4000_0000, 2'b00, 4'h0);
    check_word("R4 one const", 32'h3F80_0000, 4'h0);
    // R1 idle after result
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: idle out_valid=%b expected 0", out_valid);
    end
    apply("R4 shift", 1'b1, 140, 32'h0001_2345, 2'b00, 4'h0);
    // R6 ties and modes, R8 inexact
    apply("R6 tie even stays", 1'b0, 126, 32'h8000_0080, 2'b00, 4'h0);
    check_word("R6 tie even const", 32'h3F80_0000, 4'b0010);
    apply("R6 tie odd up", 1'b0, 126, 32'h8000_0180, 2'b00, 4'h0);
    check_word("R6 tie odd const", 32'h3F80_0002, 4'b0010);
    for (int md = 0; md < 4; md++) begin
      apply("R6 mode pos", 1'b0, 126, 32'h8000_0001, 2'(md), 4'h0);
      apply("R6 mode neg", 1'b1, 126, 32'h8000_0001, 2'(md), 4'h0);
    end
    apply("R8 exact", 1'b1, 126, 32'h8000_0100, 2'b01, 4'h0);
    check_word("R8 exact const", 32'hBF80_0001, 4'h0);
    // R7 carry out of bit 31
    apply("R7 carry", 1'b0, 126, 32'hFFFF_FFFF, 2'b00, 4'h0);
    check_word("R7 carry const", 32'h4000_0000, 4'b0010);
    apply("R7 carry up", 1'b1, 130, 32'hFFFF_FF01, 2'b10, 4'h0);
    // R9 overflow
    apply("R9 ovf nearest", 1'b0, 300, 32'h4000_0000, 2'b00, 4'h0);
    check_word("R9 ovf inf const", 32'h7F80_0000, 4'b1010);
    apply("R9 ovf zero", 1'b1, 300, 32'h4000_0000, 2'b11, 4'h0);
    check_word("R9 ovf max const", 32'hFF7F_FFFF, 4'b1010);
    apply("R9 ovf down pos", 1'b0, 280, 32'h4000_0000, 2'b10, 4'h0);
    apply("R9 ovf by carry", 1'b0, 253, 32'hFFFF_FFFF, 2'b00, 4'h0);
    apply("R9 edge no ovf", 1'b0, 254, 32'h4000_0000, 2'b00, 4'h0);
    check_word("R9 edge const", 32'h7F00_0000, 4'h0);
    apply("R9 nan no flags", 1'b0, 255, 32'h6000_0000, 2'b00, 4'h0);
    // R5 / R10 tiny results
    apply("R5 tiny exact", 1'b0, -5, 32'h8000_0000, 2'b00, 4'h0);
    apply("R10 tiny inexact", 1'b0, -20, 32'h8000_0001, 2'b00, 4'h0);
    apply("R10 tiny to normal", 1'b0, -1, 32'hFFFF_FFFF, 2'b00, 4'h0);
    check_word("R10 tiny to normal const", 32'h0080_0000, 4'b0010);
    apply("R5 deep jam", 1'b1, -100, 32'h4000_0000, 2'b10, 4'h0);
    check_word("R5 deep jam const", 32'h8000_0001, 4'b0110);
    apply("R10 deep zero", 1'b0, -100, 32'h4000_0000, 2'b00, 4'h0);
    check_word("R10 deep zero const", 32'h0000_0000, 4'b0110);
    // R2 pass-through
    apply("R2 inf", 1'b1, 255, 32'h0, 2'b01, 4'h0);
    check_word("R2 inf const", 32'hFF80_0000, 4'h0);
    apply("R2 nan flags", 1'b0, 255, 32'h2000_0080, 2'b00, 4'b0001);
    check_word("R2 nan const", 32'h7FC0_0001, 4'b0001);
    // R3 zeros
    apply("R3 zero", 1'b1, 10, 32'h0, 2'b00, 4'b0100);
    check_word("R3 zero const", 32'h8000_0000, 4'b0100);
    apply("R3 zero pos", 1'b0, -30, 32'h0, 2'b10, 4'h0);
    // R11 incoming flags merged
    apply("R11 merge", 1'b0, 126, 32'h8000_0001, 2'b00, 4'b1001);
    check_word("R11 merge const", 32'h3F80_0000, 4'b1011);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] g;
      logic [3:0]  fi;
      int          e;
      e  = int'($urandom_range(0, 360)) - 60;
      g  = $urandom;
      if ($urandom_range(0, 1) == 1) g = g >> $urandom_range(0, 31);
      fi = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(0, 15) == 0) e = 255;
      if (fi != 0) apply("R11 random", 1'($urandom), e, g, 2'($urandom), fi);
      else         apply("R4 random", 1'($urandom), e, g, 2'($urandom), fi);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule